// File: doc/BRIEF.md
# Display Data Channel EDID Responder with Hot-Plug Gating

This block makes a design look like a monitor to an upstream video source. The source is the bus master on the display data link, and the block acts as a read-only I2C target at address 0x50. From on-chip constant storage it returns a 128-byte EDID image whose preferred mode is 1920x1080. A write sets the byte pointer. Each byte read returns the byte at the pointer and then moves the pointer on, so a source can fetch the whole image in one burst or in pieces.

SCL and SDA are taken as raw pins. Both lines are synchronised and filtered in the system clock domain before any edge is acted on. SDA is open-drain: the block only ever pulls it low, through an enable.

The block also drives the hot-plug assert line to the source. That line stays low until the responder has been out of reset long enough to answer queries. After that it follows the downstream hot-plug detect input, inverted, because that input reaches the chip through an inverting open-drain stage. A receive-buffer enable output is driven high whenever the block is out of reset.

Top module: `ddc_edid_resp`

## Requirements
- R1: A transaction addressed to 7-bit address 0x50 (first byte 0xA0 for write, 0xA1 for read) is acknowledged. Any other address gets no acknowledge, and SDA stays released until the next START.
- R2: In a write transaction, the first data byte loads the byte pointer (low 7 bits). Further data bytes are acknowledged but change neither the pointer nor the image.
- R3: Each byte read returns the image byte at the pointer, then increments the pointer. The pointer wraps from 127 to 0 and keeps its value across transactions.
- R4: Image bytes 0 to 7 are 00 FF FF FF FF FF FF 00.
- R5: The sum of all 128 image bytes is 0 modulo 256.
- R6: The first detailed timing entry gives the preferred mode. Pixel clock {b55,b54} = 14850 (units of 10 kHz). Horizontal active {b58[7:4],b56} = 1920. Vertical active {b61[7:4],b59} = 1080.
- R7: When the master answers a read byte with NACK, SDA is released. Further SCL clocks are ignored until a START or STOP. A repeated START begins a new address phase.
- R8: SDA is asserted only while SCL is low. It is never driven high.
- R9: SCL and SDA each pass through a two-flop synchroniser and a FILT_LEN-sample filter. A pulse shorter than FILT_LEN clocks has no effect on a transfer.
- R10: hpa_o stays 0 for READY_DLY clocks after reset. After that it equals the inverse of hpd_n_i, within 3 clocks.
- R11: rxbuf_en_o is 0 while in reset and 1 from the first clock after reset.
- R12: In reset, sda_oe_o and hpa_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw SCL from the source |
| sda_i | input | 1 | Raw SDA bus level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| hpd_n_i | input | 1 | Downstream hot-plug detect, inverted by the board |
| hpa_o | output | 1 | Hot-plug assert toward the source |
| rxbuf_en_o | output | 1 | Receive-buffer enable |

## Verification
The bench builds the block with READY_DLY = 64 and the default FILT_LEN = 3. The short ready delay lets both sides of the hot-plug gate be seen within a few hundred clocks. With a quarter SCL period of 10 clocks, the six-clock input latency fits inside each low phase. That makes it possible to check that SDA changes only while SCL is low, and to inject a 2-clock SCL spike that the filter must swallow. One full 128-byte burst read, wrapping reads at the top of the image and an off-address access cover the pointer and address behaviour.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

  localparam int EDID_BYTES = 128;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;

  // Image content except the final checksum byte.
  function automatic logic [7:0] edid_raw(input int idx);
    logic [7:0] b;
    b = 8'h00;
    if (idx >= 1 && idx <= 6) b = 8'hFF;
    else begin
      case (idx)
        8:  b = 8'h31;
        9:  b = 8'h4C;
        10: b = 8'h01;
        16: b = 8'h01;
        17: b = 8'h20;
        18: b = 8'h01;
        19: b = 8'h03;
        20: b = 8'h80;
        21: b = 8'h35;
        22: b = 8'h1E;
        23: b = 8'h78;
        24: b = 8'h0A;
        25: b = 8'hEE;
        26: b = 8'h91;
        27: b = 8'hA3;
        28: b = 8'h54;
        29: b = 8'h4C;
        30: b = 8'h99;
        31: b = 8'h26;
        32: b = 8'h0F;
        33: b = 8'h50;
        34: b = 8'h54;
        // preferred mode: 1920x1080, 148.5 MHz
        54: b = 8'h02;
        55: b = 8'h3A;
        56: b = 8'h80;
        57: b = 8'h18;
        58: b = 8'h71;
        59: b = 8'h38;
        60: b = 8'h2D;
        61: b = 8'h40;
        62: b = 8'h58;
        63: b = 8'h2C;
        64: b = 8'h45;
        66: b = 8'h0F;
        67: b = 8'h28;
        68: b = 8'h21;
        71: b = 8'h1E;
        75: b = 8'h10;
        93: b = 8'h10;
        111: b = 8'h10;
        default: b = 8'h00;
      endcase
      if (idx >= 38 && idx <= 53) b = 8'h01;
    end
    return b;
  endfunction

  function automatic logic [7:0] edid_byte(input int idx);
    logic [7:0] sum;
    if (idx == EDID_BYTES - 1) begin
      sum = 8'h00;
      for (int i = 0; i < EDID_BYTES - 1; i++) sum = sum + edid_raw(i);
      return 8'h00 - sum;
    end
    return edid_raw(idx);
  endfunction

endpackage

// File: rtl/ddc_line_filter.sv
module ddc_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o,
  output logic rose_o,
  output logic fell_o
);

  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] win_q;
  logic                line_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      win_q  <= '1;
      line_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      win_q  <= {win_q[FILT_LEN-2:0], sync_q[1]};
      if (&win_q)       line_q <= 1'b1;
      else if (~|win_q) line_q <= 1'b0;
      prev_q <= line_q;
    end
  end

  assign line_o = line_q;
  assign rose_o = line_q & ~prev_q;
  assign fell_o = ~line_q & prev_q;

  // filtered level moves only after a full window of agreeing samples
  p_filter_agree_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_q != $past(line_q)) |-> ($past(&win_q) || $past(~|win_q)));

endmodule

// File: rtl/ddc_edid_rom.sv
module ddc_edid_rom
  import ddc_pkg::*;
#(
  parameter int AW = $clog2(EDID_BYTES)
) (
  input  logic [AW-1:0] addr_i,
  output logic [7:0]    data_o
);

  logic [7:0] img [EDID_BYTES];

  for (genvar g = 0; g < EDID_BYTES; g++) begin : g_img
    assign img[g] = edid_byte(g);
  end

  assign data_o = img[addr_i];

endmodule

// File: rtl/ddc_i2c_target.sv
module ddc_i2c_target
  import ddc_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         AW       = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          sda_rise_i,
  input  logic          sda_fall_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] ptr_o,
  output logic          sda_oe_o
);

  tgt_state_e    state_q;
  logic [3:0]    cnt_q;
  logic [7:0]    sr_q, tx_q;
  logic [AW-1:0] ptr_q;
  logic          oe_q, rw_q, first_q, nack_q;
  logic          start_c, stop_c;

  assign start_c = scl_i & sda_fall_i;
  assign stop_c  = scl_i & sda_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sr_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      nack_q  <= 1'b0;
    end else if (start_c) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
      first_q <= 1'b1;
    end else if (stop_c) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise_i) begin
            sr_q  <= {sr_q[6:0], sda_i};
            cnt_q <= cnt_q + 4'd1;
          end else if (scl_fall_i && cnt_q == 4'd8) begin
            if (sr_q[7:1] == DEV_ADDR) begin
              oe_q    <= 1'b1;
              rw_q    <= sr_q[0];
              state_q <= ST_ADDR_ACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q    <= rd_data_i;
              ptr_q   <= ptr_q + 1'b1;
              oe_q    <= ~rd_data_i[7];
              state_q <= ST_RD;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise_i) begin
            sr_q  <= {sr_q[6:0], sda_i};
            cnt_q <= cnt_q + 4'd1;
          end else if (scl_fall_i && cnt_q == 4'd8) begin
            oe_q <= 1'b1;
            if (first_q) begin
              ptr_q   <= sr_q[AW-1:0];
              first_q <= 1'b0;
            end
            state_q <= ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall_i) begin
            oe_q    <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall_i) begin
            if (cnt_q == 4'd7) begin
              oe_q    <= 1'b0;
              state_q <= ST_RD_ACK;
            end else begin
              tx_q  <= {tx_q[6:0], 1'b0};
              oe_q  <= ~tx_q[6];
              cnt_q <= cnt_q + 4'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise_i) nack_q <= sda_i;
          else if (scl_fall_i) begin
            if (nack_q) begin
              state_q <= ST_IDLE;
            end else begin
              tx_q    <= rd_data_i;
              ptr_q   <= ptr_q + 1'b1;
              oe_q    <= ~rd_data_i[7];
              cnt_q   <= '0;
              state_q <= ST_RD;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ptr_o    = ptr_q;
  assign sda_oe_o = oe_q;

  p_oe_scl_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> !scl_i);

  p_idle_released_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !oe_q);

  p_nack_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_ACK && scl_fall_i && nack_q && !start_c && !stop_c)
      |=> (state_q == ST_IDLE && !oe_q));

endmodule

// File: rtl/ddc_hpa_gate.sv
module ddc_hpa_gate #(
  parameter int READY_DLY = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hpd_n_i,
  output logic hpa_o,
  output logic rxbuf_en_o
);

  localparam int CW = $clog2(READY_DLY) + 1;

  logic [CW-1:0] cnt_q;
  logic          ready_q, hpa_q, rxbuf_q;
  logic [1:0]    hpd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
      hpd_q   <= '1;
      hpa_q   <= 1'b0;
      rxbuf_q <= 1'b0;
    end else begin
      rxbuf_q <= 1'b1;
      hpd_q   <= {hpd_q[0], hpd_n_i};
      if (!ready_q) begin
        if (cnt_q == CW'(READY_DLY - 1)) ready_q <= 1'b1;
        else                              cnt_q   <= cnt_q + 1'b1;
      end
      hpa_q <= ready_q & ~hpd_q[1];
    end
  end

  assign hpa_o      = hpa_q;
  assign rxbuf_en_o = rxbuf_q;

  p_hpa_needs_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hpa_q |-> ready_q);

endmodule

// File: rtl/ddc_edid_resp.sv
module ddc_edid_resp
  import ddc_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         FILT_LEN  = 3,
  parameter int         READY_DLY = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  input  logic hpd_n_i,
  output logic hpa_o,
  output logic rxbuf_en_o
);

  localparam int AW     = $clog2(EDID_BYTES);
  localparam int NLINES = 2;  // 0: SCL, 1: SDA

  logic [NLINES-1:0] raw, lvl, rise, fall;
  logic [AW-1:0]     ptr;
  logic [7:0]        rom_data;

  assign raw = {sda_i, scl_i};

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    ddc_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw[l]),
      .line_o (lvl[l]),
      .rose_o (rise[l]),
      .fell_o (fall[l])
    );
  end

  ddc_edid_rom #(.AW(AW)) u_rom (
    .addr_i (ptr),
    .data_o (rom_data)
  );

  ddc_i2c_target #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_tgt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (lvl[0]),
    .sda_i      (lvl[1]),
    .scl_rise_i (rise[0]),
    .scl_fall_i (fall[0]),
    .sda_rise_i (rise[1]),
    .sda_fall_i (fall[1]),
    .rd_data_i  (rom_data),
    .ptr_o      (ptr),
    .sda_oe_o   (sda_oe_o)
  );

  ddc_hpa_gate #(.READY_DLY(READY_DLY)) u_hpa (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hpd_n_i    (hpd_n_i),
    .hpa_o      (hpa_o),
    .rxbuf_en_o (rxbuf_en_o)
  );

endmodule

// File: tb/ddc_edid_resp_tb.sv
module ddc_edid_resp_tb_top;

  localparam int READY_DLY = 64;
  localparam int Q         = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic hpd_n = 1'b0;
  logic sda_oe, hpa, rxbuf_en;
  wire  sda_bus;

  int checks = 0;
  int errors = 0;
  int viol   = 0;
  bit done   = 1'b0;
  logic [7:0] img [128];

  always #10 clk = ~clk;

  assign sda_bus = ~(sda_oe | m_low);

  ddc_edid_resp #(.READY_DLY(READY_DLY)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_bus),
    .sda_oe_o   (sda_oe),
    .hpd_n_i    (hpd_n),
    .hpa_o      (hpa),
    .rxbuf_en_o (rxbuf_en)
  );

  // R8: watch for SDA drive changes while SCL is high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl) viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i_start();
    m_low = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    m_low = 1'b1; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic i_stop();
    m_low = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    m_low = 1'b0; tick(Q);
  endtask

  task automatic wbit(input logic b);
    m_low = ~b; tick(Q);
    scl = 1'b1; tick(2 * Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic rbit(input bit glitch, output logic b);
    m_low = 1'b0;
    if (glitch) begin
      tick(3); scl = 1'b1; tick(2); scl = 1'b0; tick(Q - 5);
    end else tick(Q);
    scl = 1'b1; tick(Q);
    b = sda_bus; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(1'b0, ack);
  endtask

  task automatic rbyte(input logic nack, input bit glitch, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(glitch && i == 4, b);
      d[i] = b;
    end
    wbit(nack);
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic a;
    i_start();
    wbyte(8'hA0, a); chk("R1 write addr ack", a, 0);
    wbyte(p, a);     chk("R2 pointer byte ack", a, 0);
  endtask

  task automatic t_reset();
    chk("R12 sda_oe in reset", sda_oe, 0);
    chk("R12 hpa in reset", hpa, 0);
    chk("R11 rxbuf_en in reset", rxbuf_en, 0);
    rst_n = 1'b1;
    tick(2);
    chk("R11 rxbuf_en after reset", rxbuf_en, 1);
  endtask

  task automatic t_hpa();
    tick(10);
    chk("R10 hpa low before ready", hpa, 0);
    tick(READY_DLY);
    chk("R10 hpa high once ready", hpa, 1);
    hpd_n = 1'b1; tick(4);
    chk("R10 hpa follows inverted hpd (low)", hpa, 0);
    hpd_n = 1'b0; tick(4);
    chk("R10 hpa follows inverted hpd (high)", hpa, 1);
  endtask

  task automatic t_read_all();
    logic a;
    logic [7:0] sum, d;
    set_ptr(8'h00);
    i_start();
    wbyte(8'hA1, a); chk("R1 read addr ack", a, 0);
    for (int i = 0; i < 128; i++) begin
      rbyte(i == 127, 1'b0, d);
      img[i] = d;
    end
    i_stop();
    for (int i = 0; i < 8; i++)
      chk("R4 header byte", img[i], (i == 0 || i == 7) ? 8'h00 : 8'hFF);
    sum = 8'h00;
    for (int i = 0; i < 128; i++) sum = sum + img[i];
    chk("R5 checksum", sum, 0);
    chk("R6 pixel clock", {img[55], img[54]}, 14850);
    chk("R6 h active", {img[58][7:4], img[56]}, 1920);
    chk("R6 v active", {img[61][7:4], img[59]}, 1080);
  endtask

  task automatic t_wrap();
    logic a;
    logic [7:0] d;
    set_ptr(8'd126);
    i_start();
    wbyte(8'hA1, a);
    for (int i = 0; i < 4; i++) begin
      rbyte(i == 3, 1'b0, d);
      chk("R3 wrap read", d, img[(126 + i) % 128]);
    end
    i_stop();
    i_start();
    wbyte(8'hA1, a);
    rbyte(1'b1, 1'b0, d);
    i_stop();
    chk("R3 pointer kept across transactions", d, img[2]);
  endtask

  task automatic t_bad_addr();
    logic a;
    logic [7:0] d;
    i_start();
    wbyte(8'hA4, a);
    chk("R1 foreign write addr not acked", a, 1);
    rbyte(1'b1, 1'b0, d);
    chk("R1 SDA released after foreign addr", d, 8'hFF);
    i_stop();
    i_start();
    wbyte(8'hA3, a);
    chk("R1 foreign read addr not acked", a, 1);
    i_stop();
  endtask

  task automatic t_extra_write();
    logic a;
    logic [7:0] d;
    set_ptr(8'd20);
    wbyte(8'hAA, a); chk("R2 extra byte acked", a, 0);
    wbyte(8'h55, a); chk("R2 extra byte acked", a, 0);
    i_start();
    wbyte(8'hA1, a);
    rbyte(1'b0, 1'b0, d); chk("R2 pointer from first byte", d, img[20]);
    rbyte(1'b1, 1'b0, d); chk("R2 image unchanged", d, img[21]);
    i_stop();
  endtask

  task automatic t_nack();
    logic a;
    logic [7:0] d;
    set_ptr(8'd54);
    i_start();
    wbyte(8'hA1, a);
    rbyte(1'b1, 1'b0, d); chk("R7 byte before nack", d, img[54]);
    rbyte(1'b1, 1'b0, d); chk("R7 released after nack", d, 8'hFF);
    i_start();
    wbyte(8'hA1, a); chk("R7 repeated start acked", a, 0);
    rbyte(1'b1, 1'b0, d); chk("R7 read after repeated start", d, img[55]);
    i_stop();
  endtask

  task automatic t_glitch();
    logic a;
    logic [7:0] d;
    set_ptr(8'd56);
    i_start();
    wbyte(8'hA1, a);
    rbyte(1'b0, 1'b1, d); chk("R9 glitch ignored", d, img[56]);
    rbyte(1'b1, 1'b0, d); chk("R9 next byte aligned", d, img[57]);
    i_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    t_reset();
    t_hpa();
    t_read_all();
    t_wrap();
    t_bad_addr();
    t_extra_write();
    t_nack();
    t_glitch();
    chk("R8 SDA drive changes only with SCL low", viol, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule